// File: doc/BRIEF.md
# DMA Controller Register Front End

This block is the register file that software programs for a four-channel DMA controller with an 8-bit data bus. The host reaches sixteen byte-wide ports through a 4-bit port address, a select and read and write strobes. Each channel has a 16-bit address register and a 16-bit count register, each kept as a base copy and a current copy, plus an 8-bit mode register. The block also holds a command register, terminal-count flags, software request bits, mask bits, a temporary register and the shared byte pointer. That pointer decides whether each access to an address or count register reaches the low byte or the high byte.

A separate transfer engine reads the per-channel configuration, enables, masks and software requests from the outputs. It returns three things: terminal-count pulses, hardware request levels and one-cycle step pulses that advance a channel's current address and count. Reads are combinational while the read strobe is high. Every state change takes effect at the rising edge that samples the strobe or pulse.

Top module: `dmac_reg_front`

## Requirements
- R1: For channel n, port 2n is the address register and port 2n+1 is the count register. A write updates the selected byte of both the base and the current copy. A read returns the selected byte of the current copy.
- R2: The byte pointer starts at 0, which selects the low byte. It toggles after every read or write of ports 0 to 7. A write of any value to port 12 returns it to 0.
- R3: A write to port 8 loads the command register, which is driven on `cmd_word`. While command bit 2 (controller disable) is 1, `ch_enable` is all zero.
- R4: A read of port 8 returns the terminal-count flags of channels 0 to 3 in bits 3:0 and the request levels of channels 0 to 3 in bits 7:4. Each request level is the software request ORed with `hw_req`. The read clears all terminal-count flags.
- R5: When a terminal-count pulse arrives in the same cycle as a status read, that channel's flag is set afterwards.
- R6: A write to port 9 updates the software request of the channel given by data bits 1:0. Bit 2 set to 1 sets the request and bit 2 set to 0 clears it.
- R7: A write to port 10 uses the same format as port 9 but acts on the mask bit. `ch_enable[n]` is 1 exactly when mask n is 0 and the controller is not disabled.
- R8: A write of any value to port 14 clears all four masks. A write to port 15 sets mask n to data bit n.
- R9: A write to port 11 loads the whole data byte into the mode register of the channel given by data bits 1:0. The other three mode registers are left alone. Bit 4 of a mode register enables autoinitialisation and bit 5 selects decrement.
- R10: Reset, and a write of any value to port 13, set all masks and clear the command register, the terminal-count flags, the software requests, the temporary register and the byte pointer. Mode registers keep their values across both.
- R11: `temp_ld` loads `temp_din` into the temporary register, and a read of port 13 returns it.
- R12: A `xfer_step` pulse decrements the channel's current count. It also moves the current address down by one when mode bit 5 is set, or up by one otherwise.
- R13: A terminal-count pulse sets the channel's flag and clears its software request. With autoinitialisation enabled, it reloads the current address and count from the base copies. Otherwise it sets the channel's mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register port select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 4 | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| hw_req | input | 4 | Hardware request levels from the engine |
| tc_pulse | input | 4 | Terminal-count pulses from the engine |
| xfer_step | input | 4 | One-transfer step pulses from the engine |
| temp_ld | input | 1 | Load strobe for the temporary register |
| temp_din | input | 8 | Temporary register data from the engine |
| cmd_word | output | 8 | Command register |
| ch_mode | output | 32 | Mode registers, channel n in bits 8n+7:8n |
| ch_addr | output | 64 | Current addresses, channel n in bits 16n+15:16n |
| ch_count | output | 64 | Current counts, channel n in bits 16n+15:16n |
| ch_mask | output | 4 | Mask bits |
| ch_enable | output | 4 | Channel enables |
| sw_req | output | 4 | Software request bits |

## Verification
Read data is due in the same cycle as the read strobe. The monitor samples it at the falling edge inside that strobe cycle and pops the expected byte that the driver queued when it raised the strobe. Register, mask, request and flag changes are due one rising edge after the write, step or terminal-count pulse. The bench compares them only after the driver task has lowered the strobe past that edge. A status read that coincides with a terminal-count pulse is checked twice: once by the queued read in that cycle, and once by a second status read that must still show the new flag.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH    = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SEL_W  = $clog2(NCH);

  localparam logic [3:0] P_CMD_STAT = 4'd8;
  localparam logic [3:0] P_SWREQ    = 4'd9;
  localparam logic [3:0] P_MASK1    = 4'd10;
  localparam logic [3:0] P_MODE     = 4'd11;
  localparam logic [3:0] P_PTRCLR   = 4'd12;
  localparam logic [3:0] P_TMP_MCLR = 4'd13;
  localparam logic [3:0] P_MASKCLR  = 4'd14;
  localparam logic [3:0] P_MASKALL  = 4'd15;

  localparam int MODE_AUTO = 4;
  localparam int MODE_DEC  = 5;
  localparam int CMD_OFF   = 2;
  localparam int SET_BIT   = 2;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_adr,
  input  logic              wr_cnt,
  input  logic              hi_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mode_we,
  input  logic              step,
  input  logic              tc,
  output logic [WORD_W-1:0] cur_adr,
  output logic [WORD_W-1:0] cur_cnt,
  output logic [BYTE_W-1:0] mode
);
  logic [WORD_W-1:0] base_adr_q, base_adr_d, cur_adr_q, cur_adr_d;
  logic [WORD_W-1:0] base_cnt_q, base_cnt_d, cur_cnt_q, cur_cnt_d;
  logic [BYTE_W-1:0] mode_q;

  always_comb begin
    base_adr_d = base_adr_q;
    cur_adr_d  = cur_adr_q;
    base_cnt_d = base_cnt_q;
    cur_cnt_d  = cur_cnt_q;
    if (wr_adr || wr_cnt) begin
      if (wr_adr) begin
        if (hi_sel) begin
          base_adr_d[WORD_W-1:BYTE_W] = wdata;
          cur_adr_d[WORD_W-1:BYTE_W]  = wdata;
        end else begin
          base_adr_d[BYTE_W-1:0] = wdata;
          cur_adr_d[BYTE_W-1:0]  = wdata;
        end
      end
      if (wr_cnt) begin
        if (hi_sel) begin
          base_cnt_d[WORD_W-1:BYTE_W] = wdata;
          cur_cnt_d[WORD_W-1:BYTE_W]  = wdata;
        end else begin
          base_cnt_d[BYTE_W-1:0] = wdata;
          cur_cnt_d[BYTE_W-1:0]  = wdata;
        end
      end
    end else if (tc && mode_q[MODE_AUTO]) begin
      cur_adr_d = base_adr_q;
      cur_cnt_d = base_cnt_q;
    end else if (step) begin
      cur_adr_d = mode_q[MODE_DEC] ? cur_adr_q - 1'b1 : cur_adr_q + 1'b1;
      cur_cnt_d = cur_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_adr_q <= '0;
      cur_adr_q  <= '0;
      base_cnt_q <= '0;
      cur_cnt_q  <= '0;
    end else begin
      base_adr_q <= base_adr_d;
      cur_adr_q  <= cur_adr_d;
      base_cnt_q <= base_cnt_d;
      cur_cnt_q  <= cur_cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mode_we) mode_q <= wdata;
  end

  assign cur_adr = cur_adr_q;
  assign cur_cnt = cur_cnt_q;
  assign mode    = mode_q;
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_cmd,
  input  logic              wr_req,
  input  logic              wr_mask1,
  input  logic              wr_ptrclr,
  input  logic              wr_mclr,
  input  logic              wr_maskclr,
  input  logic              wr_maskall,
  input  logic              rd_stat,
  input  logic              acc_ch,
  input  logic [NCH-1:0]    tc,
  input  logic [NCH-1:0]    autoinit,
  input  logic              temp_ld,
  input  logic [BYTE_W-1:0] temp_din,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [NCH-1:0]    tcf_q,
  output logic [NCH-1:0]    sreq_q,
  output logic [NCH-1:0]    mask_q,
  output logic [BYTE_W-1:0] temp_q,
  output logic              ptr_q
);
  logic [BYTE_W-1:0] cmd_d, temp_d;
  logic [NCH-1:0]    tcf_d, sreq_d, mask_d;
  logic              ptr_d;
  logic [SEL_W-1:0]  sel;

  assign sel = wdata[SEL_W-1:0];

  always_comb begin
    cmd_d  = cmd_q;
    tcf_d  = tcf_q;
    sreq_d = sreq_q;
    mask_d = mask_q;
    temp_d = temp_q;
    ptr_d  = ptr_q;
    if (wr_mclr) begin
      cmd_d  = '0;
      tcf_d  = '0;
      sreq_d = '0;
      mask_d = '1;
      temp_d = '0;
      ptr_d  = 1'b0;
    end else begin
      if (wr_cmd)     cmd_d = wdata;
      if (rd_stat)    tcf_d = '0;
      if (wr_req)     sreq_d[sel] = wdata[SET_BIT];
      if (wr_mask1)   mask_d[sel] = wdata[SET_BIT];
      if (wr_maskclr) mask_d = '0;
      if (wr_maskall) mask_d = wdata[NCH-1:0];
      if (temp_ld)    temp_d = temp_din;
      if (wr_ptrclr)  ptr_d = 1'b0;
      else if (acc_ch) ptr_d = ~ptr_q;
      tcf_d  = tcf_d | tc;
      sreq_d = sreq_d & ~tc;
      mask_d = mask_d | (tc & ~autoinit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      tcf_q  <= '0;
      sreq_q <= '0;
      mask_q <= '1;
      temp_q <= '0;
      ptr_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      tcf_q  <= tcf_d;
      sreq_q <= sreq_d;
      mask_q <= mask_d;
      temp_q <= temp_d;
      ptr_q  <= ptr_d;
    end
  end
endmodule

// File: rtl/dmac_reg_front.sv
module dmac_reg_front
  import dmac_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int DW   = BYTE_W,
  localparam int AW  = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [N_CH-1:0]   hw_req,
  input  logic [N_CH-1:0]   tc_pulse,
  input  logic [N_CH-1:0]   xfer_step,
  input  logic              temp_ld,
  input  logic [DW-1:0]     temp_din,
  output logic [DW-1:0]     cmd_word,
  output logic [N_CH*DW-1:0] ch_mode,
  output logic [N_CH*AW-1:0] ch_addr,
  output logic [N_CH*AW-1:0] ch_count,
  output logic [N_CH-1:0]   ch_mask,
  output logic [N_CH-1:0]   ch_enable,
  output logic [N_CH-1:0]   sw_req
);
  logic wr_s, rd_s, in_ch;
  logic [SEL_W-1:0] ch_idx;
  logic ptr_hi;
  logic [N_CH-1:0] tc_flags, autoinit;
  logic [DW-1:0]   temp_q;
  logic [AW-1:0]   adr_a [N_CH];
  logic [AW-1:0]   cnt_a [N_CH];
  logic [AW-1:0]   word;

  assign wr_s   = cs & wr;
  assign rd_s   = cs & rd;
  assign in_ch  = ~addr[3];
  assign ch_idx = addr[SEL_W:1];

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic [DW-1:0] mode_n;
    dmac_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_adr  (wr_s & in_ch & (ch_idx == n) & ~addr[0]),
      .wr_cnt  (wr_s & in_ch & (ch_idx == n) & addr[0]),
      .hi_sel  (ptr_hi),
      .wdata   (wdata),
      .mode_we (wr_s & (addr == P_MODE) & (wdata[SEL_W-1:0] == n)),
      .step    (xfer_step[n]),
      .tc      (tc_pulse[n]),
      .cur_adr (adr_a[n]),
      .cur_cnt (cnt_a[n]),
      .mode    (mode_n)
    );
    assign autoinit[n]           = mode_n[MODE_AUTO];
    assign ch_mode[n*DW +: DW]   = mode_n;
    assign ch_addr[n*AW +: AW]   = adr_a[n];
    assign ch_count[n*AW +: AW]  = cnt_a[n];
  end

  dmac_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdata      (wdata),
    .wr_cmd     (wr_s & (addr == P_CMD_STAT)),
    .wr_req     (wr_s & (addr == P_SWREQ)),
    .wr_mask1   (wr_s & (addr == P_MASK1)),
    .wr_ptrclr  (wr_s & (addr == P_PTRCLR)),
    .wr_mclr    (wr_s & (addr == P_TMP_MCLR)),
    .wr_maskclr (wr_s & (addr == P_MASKCLR)),
    .wr_maskall (wr_s & (addr == P_MASKALL)),
    .rd_stat    (rd_s & (addr == P_CMD_STAT)),
    .acc_ch     ((wr_s | rd_s) & in_ch),
    .tc         (tc_pulse),
    .autoinit   (autoinit),
    .temp_ld    (temp_ld),
    .temp_din   (temp_din),
    .cmd_q      (cmd_word),
    .tcf_q      (tc_flags),
    .sreq_q     (sw_req),
    .mask_q     (ch_mask),
    .temp_q     (temp_q),
    .ptr_q      (ptr_hi)
  );

  assign ch_enable = ~ch_mask & {N_CH{~cmd_word[CMD_OFF]}};

  always_comb begin
    word  = addr[0] ? cnt_a[ch_idx] : adr_a[ch_idx];
    rdata = '0;
    if (rd_s) begin
      if (in_ch)                    rdata = ptr_hi ? word[AW-1:DW] : word[DW-1:0];
      else if (addr == P_CMD_STAT)  rdata = {sw_req | hw_req, tc_flags};
      else if (addr == P_TMP_MCLR)  rdata = temp_q;
    end
  end
endmodule

// File: rtl/dmac_reg_front_chk.sv
module dmac_reg_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rd,
  input logic       wr,
  input logic [3:0] addr,
  input logic [3:0] tc_pulse,
  input logic [7:0] cmd_word,
  input logic [3:0] ch_mask,
  input logic [3:0] sw_req,
  input logic       ptr_hi,
  input logic [3:0] tc_flags
);
  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (rd || wr) && !addr[3]) |=> (ptr_hi != $past(ptr_hi))); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 4'd12) |=> !ptr_hi); // R2
  AST_TC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse && !(cs && wr && addr == 4'd13)) |=> ((tc_flags & $past(tc_pulse)) == $past(tc_pulse))); // R13
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 4'd8 && tc_pulse == 4'd0) |=> (tc_flags == 4'd0)); // R4
  AST_MASK_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 4'd14 && tc_pulse == 4'd0) |=> (ch_mask == 4'd0)); // R8
  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 4'd13) |=> (ch_mask == 4'hF && cmd_word == 8'd0 && sw_req == 4'd0)); // R10
endmodule

bind dmac_reg_front dmac_reg_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .tc_pulse(tc_pulse), .cmd_word(cmd_word), .ch_mask(ch_mask),
  .sw_req(sw_req), .ptr_hi(ptr_hi), .tc_flags(tc_flags)
);

// File: tb/dmac_reg_front_tb.sv
`timescale 1ns/1ps
module dmac_reg_front_tb;
  logic clk = 1'b0;
  logic rst_n, cs, rd, wr, temp_ld;
  logic [3:0] addr, hw_req, tc_pulse, xfer_step;
  logic [7:0] wdata, rdata, temp_din, cmd_word;
  logic [31:0] ch_mode;
  logic [63:0] ch_addr, ch_count;
  logic [3:0] ch_mask, ch_enable, sw_req;
  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dmac_reg_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .hw_req(hw_req), .tc_pulse(tc_pulse),
    .xfer_step(xfer_step), .temp_ld(temp_ld), .temp_din(temp_din),
    .cmd_word(cmd_word), .ch_mode(ch_mode), .ch_addr(ch_addr),
    .ch_count(ch_count), .ch_mask(ch_mask), .ch_enable(ch_enable),
    .sw_req(sw_req)
  );

  // monitor: read data is due in the strobe cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && cs && rd) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: got %02h expected none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata got %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_port(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 cs = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; wr = 0;
  endtask

  task automatic rd_port(input logic [3:0] a, input logic [7:0] e, input string tag,
                         input logic [3:0] tcm = 4'd0);
    @(posedge clk); #1 cs = 1; rd = 1; addr = a; tc_pulse = tcm;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1 cs = 0; rd = 0; tc_pulse = 4'd0;
  endtask

  task automatic pulse(input logic [3:0] tcm, input logic [3:0] stm);
    @(posedge clk); #1 tc_pulse = tcm; xfer_step = stm;
    @(posedge clk); #1 tc_pulse = 4'd0; xfer_step = 4'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    hw_req = 0; tc_pulse = 0; xfer_step = 0; temp_ld = 0; temp_din = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(ch_mask, 4'hF, "R10 reset masks");
    chk(cmd_word, 8'h00, "R10 reset command");
    chk(ch_enable, 4'h0, "R7 reset enables");
    rd_port(8, 8'h00, "R10 reset status");

    // R9 modes: ch0 single/autoinit/read, ch1 single/decrement/write
    wr_port(11, 8'h58); wr_port(11, 8'h65); wr_port(11, 8'h42); wr_port(11, 8'h43);
    chk(ch_mode, 32'h4342_6558, "R9 mode registers");

    // R1 address/count, low then high
    wr_port(0, 8'h34); wr_port(0, 8'h12); wr_port(1, 8'h03); wr_port(1, 8'h00);
    chk(ch_addr[15:0], 16'h1234, "R1 ch0 address");
    chk(ch_count[15:0], 16'h0003, "R1 ch0 count");
    rd_port(0, 8'h34, "R1 ch0 addr low");
    rd_port(0, 8'h12, "R1 ch0 addr high");
    wr_port(2, 8'h00); wr_port(2, 8'h20); wr_port(3, 8'h05); wr_port(3, 8'h00);

    // R2 pointer clear
    wr_port(0, 8'hAA); wr_port(12, 8'h5A);
    rd_port(0, 8'hAA, "R2 low after pointer clear");
    rd_port(0, 8'h12, "R2 high after toggle");

    // R3 / R7 / R8 enables and masks
    wr_port(14, 8'hC3);
    chk(ch_enable, 4'hF, "R8 clear all masks");
    wr_port(8, 8'h04);
    chk(cmd_word, 8'h04, "R3 command load");
    chk(ch_enable, 4'h0, "R3 controller disable");
    wr_port(8, 8'h00);
    wr_port(10, 8'h06);
    chk(ch_enable, 4'hB, "R7 single mask set");
    wr_port(10, 8'h02);
    chk(ch_mask, 4'h0, "R7 single mask clear");
    wr_port(15, 8'h0A);
    chk(ch_mask, 4'hA, "R8 write all masks");
    wr_port(14, 8'h00);

    // R6 / R4 requests
    wr_port(9, 8'h05);
    chk(sw_req, 4'h2, "R6 set request");
    rd_port(8, 8'h20, "R4 status sw request");
    hw_req = 4'h8;
    rd_port(8, 8'hA0, "R4 status hw request");
    wr_port(9, 8'h01);
    chk(sw_req, 4'h0, "R6 clear request");

    // R12 steps
    pulse(4'h0, 4'h2); pulse(4'h0, 4'h2);
    rd_port(2, 8'hFE, "R12 decrement low");
    rd_port(2, 8'h1F, "R12 decrement high");
    rd_port(3, 8'h03, "R12 count low");
    rd_port(3, 8'h00, "R12 count high");
    pulse(4'h0, 4'h1);
    chk(ch_addr[15:0], 16'h12AB, "R12 increment");
    chk(ch_count[15:0], 16'h0002, "R12 count down");

    // R13 terminal count
    wr_port(9, 8'h04);
    pulse(4'h1, 4'h0);
    chk(ch_addr[15:0], 16'h12AA, "R13 autoinit address");
    chk(ch_count[15:0], 16'h0003, "R13 autoinit count");
    chk({sw_req, ch_mask}, 8'h00, "R13 request cleared, mask kept");
    rd_port(8, 8'h81, "R13 flag set");
    rd_port(8, 8'h80, "R4 flags cleared by read");
    pulse(4'h2, 4'h0);
    chk(ch_mask, 4'h2, "R13 mask set without autoinit");
    chk(ch_addr[31:16], 16'h1FFE, "R13 no reload");

    // R5 coincident pulse and status read
    rd_port(8, 8'h82, "R5 read during pulse", 4'h4);
    rd_port(8, 8'h84, "R5 flag kept");
    rd_port(8, 8'h80, "R5 cleared next read");

    // R11 temporary register
    @(posedge clk); #1 temp_ld = 1; temp_din = 8'h5C;
    @(posedge clk); #1 temp_ld = 0;
    rd_port(13, 8'h5C, "R11 temp read");

    // R10 master clear
    wr_port(8, 8'h10); wr_port(9, 8'h07); wr_port(0, 8'h11);
    pulse(4'h1, 4'h0);
    wr_port(13, 8'h00);
    chk(ch_mask, 4'hF, "R10 masks set");
    chk(cmd_word, 8'h00, "R10 command cleared");
    chk(sw_req, 4'h0, "R10 requests cleared");
    chk(ch_mode[7:0], 8'h58, "R10 mode kept");
    rd_port(0, 8'h11, "R10 pointer cleared");
    rd_port(8, 8'h80, "R10 flags cleared");
    rd_port(13, 8'h00, "R10 temp cleared");

    @(negedge clk);
    chk(exp_q.size(), 0, "R4 scoreboard drained");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule